// File: doc/BRIEF.md
# Byte-Wide Configuration Stream Loader

The loader sits on the configuration port of one device in a chain of devices. On every clock with the global select high it takes one byte. It checks a fixed seven-byte header, and then it takes a set number of frames. Each frame is a start byte, a fixed number of payload bytes and a fixed check byte. Every payload byte goes out on a one-cycle write strobe. No length field exists: the loader counts frames to know when its share of the stream has ended.

All devices in the chain take the header at the same time. Each device takes its own frames only while its chain input is high. The chain input of the first device is tied high, and every other chain input comes from the chain output of the device before it. After its last frame the loader raises its chain output to hand the stream on. It then counts start-up clocks and raises done. A bad fixed byte stops loading, and the open-drain-style init flag goes low. The flag stays low until a reset or a program pulse arrives.

Top module: `cfg_byte_loader`

Bit patterns below are written D0 first. The hex values are the `din` values, with D0 on `din[0]`.

## Requirements
- R1: After reset `init_n` is 1, and `chain_out`, `done` and `wr_en` are 0.
- R2: The header is seven bytes. Byte 3 must be the preamble 11110010 (8'h4F). Byte 7 must be the header check 11010010 (8'h4B). Bytes 1, 2, 4, 5 and 6 are fill bytes, and their values are ignored.
- R3: Each of the `FRAMES` frames is a start byte 11111110 (8'h7F), then `FRAME_BYTES` payload bytes, then the check byte 11010010 (8'h4B).
- R4: Each accepted payload byte appears on `wr_data`, with `wr_en` high for one cycle, on the clock after the byte is taken. Payload bytes appear in stream order. No other byte is strobed.
- R5: A byte is taken only on a clock with `cs` high. Header bytes are taken whatever `chain_in` is. Frame bytes are taken only when `chain_in` is also high.
- R6: A wrong preamble, header check, start or frame check byte drives `init_n` low on the next clock. Loading then stops, with no further writes. The state holds until reset or `prog_n`.
- R7: `chain_out` goes high on the clock after the last check byte of the last frame is accepted. It stays high until reset or `prog_n`.
- R8: After the last frame, `done` goes high after `STARTUP_CLKS` further clocks with `cs` high. `STARTUP_CLKS` is 6 or more. The byte values during these clocks are ignored.
- R9: While `prog_n` is low on a clock, the loader returns to its reset state and waits for a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_n | input | 1 | Synchronous restart, active low |
| cs | input | 1 | Global select; a byte is offered on each clock with this high |
| chain_in | input | 1 | Frame enable from the previous device (tie high on the first device) |
| din | input | 8 | Configuration byte, D0 on bit 0 |
| wr_en | output | 1 | One-cycle strobe for a payload byte |
| wr_data | output | 8 | Payload byte |
| init_n | output | 1 | Low after a bad fixed byte |
| chain_out | output | 1 | Enables the next device's frames |
| done | output | 1 | Start-up count complete |

## Verification
A wrong position count shows at the ports within a single frame. The payload strobes come out shifted or short, or a good check byte is read as a payload byte and `init_n` drops on the next clock. A wrong frame or start-up count shows as `chain_out` or `done` rising one or more clocks early or late. A bench model runs the same stream and compares every output on every clock. Any such fault is therefore flagged on the first clock where the outputs differ. This is usually within one frame of where the state goes wrong.

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int FRAMES       = 3,
  parameter int FRAME_BYTES  = 4,
  parameter int STARTUP_CLKS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_n,
  input  logic       cs,
  input  logic       chain_in,
  input  logic [7:0] din,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       init_n,
  output logic       chain_out,
  output logic       done
);
  localparam logic [7:0] PRE = 8'h4F;
  localparam logic [7:0] CHK = 8'h4B;
  localparam logic [7:0] SOF = 8'h7F;
  localparam int MX1 = (FRAME_BYTES + 2 > 7) ? FRAME_BYTES + 2 : 7;
  localparam int MX  = (STARTUP_CLKS > MX1) ? STARTUP_CLKS : MX1;
  localparam int PW  = $clog2(MX + 1);
  localparam int FW  = $clog2(FRAMES + 1);

  typedef enum logic [2:0] {S_HDR, S_FRM, S_UP, S_DONE, S_ERR} st_t;
  st_t st;
  logic [PW-1:0] pos;
  logic [FW-1:0] frm;

  wire take = cs && (st == S_HDR || st == S_UP || (st == S_FRM && chain_in));

  assign init_n    = (st != S_ERR);
  assign chain_out = (st == S_UP) || (st == S_DONE);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HDR; pos <= '0; frm <= '0; wr_en <= 1'b0; wr_data <= '0;
    end else if (!prog_n) begin
      st <= S_HDR; pos <= '0; frm <= '0; wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (take) begin
        unique case (st)
          S_HDR: begin
            if ((pos == PW'(2) && din != PRE) || (pos == PW'(6) && din != CHK)) st <= S_ERR;
            else if (pos == PW'(6)) begin st <= S_FRM; pos <= '0; end
            else pos <= pos + 1'b1;
          end
          S_FRM: begin
            if (pos == '0) begin
              if (din != SOF) st <= S_ERR;
              else pos <= PW'(1);
            end else if (pos <= PW'(FRAME_BYTES)) begin
              wr_en <= 1'b1; wr_data <= din; pos <= pos + 1'b1;
            end else if (din != CHK) st <= S_ERR;
            else begin
              pos <= '0;
              frm <= frm + 1'b1;
              if (frm == FW'(FRAMES - 1)) st <= S_UP;
            end
          end
          S_UP: begin
            if (pos == PW'(STARTUP_CLKS - 1)) st <= S_DONE;
            else pos <= pos + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_n && prog_n) |=> !init_n);
  a_r6_no_write_in_err: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> !wr_en);
  a_r7_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_out && prog_n) |=> chain_out);
  a_r8_done_after_chain: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> chain_out);
  a_r5_write_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cs && chain_in && prog_n));
  a_r9_prog_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (init_n && !chain_out && !done && !wr_en));
endmodule

// File: tb/cfg_byte_loader_bench.sv
module cfg_byte_loader_bench;
  localparam int FR = 3, FB = 4, SU = 6;
  logic clk = 0, rst_n = 0, prog_n = 1, cs = 0, chain_in = 0;
  logic [7:0] din = 0;
  logic wr_en, init_n, chain_out, done;
  logic [7:0] wr_data;
  int total = 0, bad = 0, writes = 0;

  always #2.5 clk = ~clk;

  cfg_byte_loader #(.FRAMES(FR), .FRAME_BYTES(FB), .STARTUP_CLKS(SU)) u_cfg_byte_loader (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .cs(cs), .chain_in(chain_in), .din(din),
    .wr_en(wr_en), .wr_data(wr_data), .init_n(init_n), .chain_out(chain_out), .done(done));

  // behavioural reference: phase 0 header, 1 frames, 2 start-up, 3 done, 4 halted
  int m_ph = 0, m_i = 0, m_f = 0;
  bit m_wr = 0;
  logic [7:0] m_wd = 0;
  logic [7:0] hdr_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !prog_n) begin m_ph = 0; m_i = 0; m_f = 0; m_wr = 0; end
    else begin
      m_wr = 0;
      if (cs) begin
        if (m_ph == 0) begin
          if ((m_i == 2 && din != 8'h4F) || (m_i == 6 && din != 8'h4B)) m_ph = 4;
          else begin m_i++; if (m_i == 7) begin m_ph = 1; m_i = 0; end end
        end else if (m_ph == 1 && chain_in) begin
          if (m_i == 0) begin if (din != 8'h7F) m_ph = 4; else m_i = 1; end
          else if (m_i <= FB) begin m_wr = 1; m_wd = din; m_i++; end
          else if (din != 8'h4B) m_ph = 4;
          else begin m_i = 0; m_f++; if (m_f == FR) m_ph = 2; end
        end else if (m_ph == 2) begin
          m_i++; if (m_i == SU) m_ph = 3;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_en) writes++;
    chk(wr_en == m_wr && (!m_wr || wr_data == m_wd), "R4 write", {wr_en, wr_data}, {m_wr, m_wd});
    chk(init_n == (m_ph != 4), "R6 init_n", init_n, m_ph != 4);
    chk(chain_out == (m_ph == 2 || m_ph == 3), "R7 chain_out", chain_out, m_ph == 2 || m_ph == 3);
    chk(done == (m_ph == 3), "R8 done", done, m_ph == 3);
  end

  task automatic put(logic [7:0] b, bit c, bit ch);
    @(negedge clk); din = b; cs = c; chain_in = ch;
  endtask
  task automatic idle(int n);
    repeat (n) put($urandom, 0, $urandom);
  endtask
  task automatic header(logic [7:0] pre, logic [7:0] hc, bit ch);
    for (int i = 0; i < 7; i++) begin
      if (i == 3) put($urandom, 0, 1);
      put(i == 2 ? pre : (i == 6 ? hc : 8'($urandom)), 1, ch);
    end
  endtask
  task automatic frame(logic [7:0] sb, logic [7:0] cb);
    put(sb, 1, 1);
    for (int i = 0; i < FB; i++) begin
      if (i == 1) put($urandom, 1, 0);
      put($urandom, 1, 1);
    end
    put(cb, 1, 1);
  endtask
  task automatic pulse_prog;
    @(negedge clk); prog_n = 0; cs = 0;
    @(negedge clk); prog_n = 1;
    chk(init_n && !chain_out && !done && !wr_en, "R9 prog restart", {init_n, chain_out, done}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(init_n && !chain_out && !done && !wr_en, "R1 reset", {init_n, chain_out, done, wr_en}, 4'b1000);
    rst_n = 1;
    // normal load, header with chain_in low, random fill bytes
    header(8'h4F, 8'h4B, 0);
    @(negedge clk); cs = 0;
    chk(init_n, "R2 fill ignored", init_n, 1);
    for (int f = 0; f < FR; f++) frame(8'h7F, 8'h4B);
    @(negedge clk); cs = 0;
    chk(chain_out && !done, "R3 frames taken", {chain_out, done}, 2'b10);
    chk(writes == FR * FB, "R4 write count", writes, FR * FB);
    idle(4);
    chk(!done, "R5 start-up needs cs", done, 0);
    for (int i = 0; i < SU; i++) put($urandom, 1, $urandom);
    @(negedge clk); cs = 0;
    chk(done, "R8 done after start-up", done, 1);
    // bad preamble
    pulse_prog;
    header(8'h4E, 8'h4B, 1);
    frame(8'h7F, 8'h4B);
    @(negedge clk); cs = 0;
    chk(!init_n && !chain_out, "R6 bad preamble", {init_n, chain_out}, 0);
    // bad header check
    pulse_prog;
    header(8'h4F, 8'hD2, 1);
    @(negedge clk); cs = 0;
    chk(!init_n, "R6 bad header check", init_n, 0);
    // bad frame check after one good frame
    rst_n = 0; @(negedge clk); rst_n = 1;
    writes = 0;
    header(8'h4F, 8'h4B, 1);
    frame(8'h7F, 8'h4B);
    frame(8'h7F, 8'hFF);
    frame(8'h7F, 8'h4B);
    @(negedge clk); cs = 0;
    chk(!init_n && writes == 2 * FB, "R6 bad frame check halts", writes, 2 * FB);
    // bad start byte
    pulse_prog;
    header(8'h4F, 8'h4B, 1);
    frame(8'hFE, 8'h4B);
    @(negedge clk); cs = 0;
    chk(!init_n, "R3 bad start byte", init_n, 0);
    // frames withheld while chain_in low
    pulse_prog;
    header(8'h4F, 8'h4B, 1);
    for (int i = 0; i < 10; i++) put(8'h00, 1, 0);
    @(negedge clk); cs = 0;
    chk(init_n && !chain_out, "R5 chain_in low holds frames", {init_n, chain_out}, 2'b10);
    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule